// File: doc/BRIEF.md
# Circular Return-Address Stack

This block is the control stack of a processor front end. Each entry pairs a return program counter with a separate status word. The entries sit in a ring of `DEPTH` slots, and three registers track them: an eldest index, a youngest index and an entry count. Calls push at the youngest end. Returns read the youngest PC as the return address and then drop that entry.

Privileged software reaches both ends of the ring through a small register-style port.
- Reading the eldest PC is destructive: it spills the oldest entry.
- Writing the eldest PC opens a new slot in front of the current eldest: it refills an entry.
- Accesses to the eldest status word, the youngest PC or the youngest status word neither move an index nor change the count.

Every accepted register access is answered with an acknowledge that arrives a fixed number of cycles late. This models the extra cost of these registers. A push is refused with an overflow pulse when it would take the count above a threshold, which leaves room for a trap handler to run. Popping or inspecting an empty stack raises a sticky error flag, because the stack itself performs no guard.

Top module: `ret_addr_ring`

## Requirements
- R1: After reset, `count_o` is 0 and `err_o`, `reg_ack_o` and `ovf_o` are 0.
- R2: A cycle with `call_i`=1 and `ret_i`=0, below the threshold, stores `call_pc_i` and `call_st_i` in a new youngest entry and raises the count by one. After that edge, `ret_pc_o` shows the new PC.
- R3: A cycle with `ret_i`=1 and `call_i`=0, on a non-empty stack, lowers the count by one. `ret_pc_o` then shows the previous youngest PC, so entries leave in last-in, first-out order.
- R4: If `call_i` and `ret_i` are both 1 on a non-empty stack, the youngest entry is replaced by the call's PC and status and the count does not change. On an empty stack the same cycle sets `err_o` and performs a plain push.
- R5: A youngest-end call alone, or an eldest-PC write, issued while the count is at least `OVF_LIMIT` (default `DEPTH`-2) changes no state and gives no acknowledge. `ovf_o` is then 1 for exactly the cycle after that edge.
- R6: An eldest-PC write (`reg_sel_i`=0, `reg_we_i`=1) places `reg_wdata_i` in a new eldest slot in front of the old eldest and clears that slot's status to 0. The count rises by one.
- R7: An eldest-PC read (`reg_sel_i`=0, `reg_we_i`=0) on a non-empty stack returns the eldest PC. It then moves the eldest index to the next entry and lowers the count by one.
- R8: The following accesses read or write the selected field and leave the count and both indices unchanged. `reg_sel_i`=1 selects the eldest status, 2 the youngest PC and 3 the youngest status. Status values are the low `ST_W` bits, and status reads are zero-extended.
- R9: An accepted register request is answered by `reg_ack_o`, high for one cycle. It rises at the edge `EXTRA_CYC` (default 4) clock edges after the accepting edge, and `reg_rdata_o` holds the read value while it is high. A request arriving before that acknowledge cycle has ended is ignored.
- R10: A register request in a cycle where `call_i` or `ret_i` is 1 is ignored and is never acknowledged.
- R11: A return, an eldest-PC read, or any `reg_sel_i` 1..3 access on an empty stack sets `err_o`. A pop on an empty stack leaves the count at 0. `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Push a return PC at the youngest end |
| call_pc_i | input | PC_W | Return PC to push |
| call_st_i | input | ST_W | Status word to push |
| ret_i | input | 1 | Pop the youngest entry |
| ret_pc_o | output | PC_W | PC of the youngest entry |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | 0 eldest PC, 1 eldest status, 2 youngest PC, 3 youngest status |
| reg_wdata_i | input | PC_W | Write data |
| reg_rdata_o | output | PC_W | Read data, valid with acknowledge |
| reg_ack_o | output | 1 | Access completed |
| ovf_o | output | 1 | Push refused: overflow trap |
| count_o | output | $clog2(DEPTH+1) | Number of entries held |
| err_o | output | 1 | Sticky empty-stack access flag |

## Verification
A call and a return can arrive together, and the youngest end then has to act as an in-place replace rather than a push followed by a pop. The bench drives both strobes in one cycle, both on a populated stack and on an empty one. A queue model predicts the result: the count stays the same and the youngest PC becomes the new call PC, except that on an empty stack a push and the error flag are expected. The same mixed cycles also occur inside a long pseudo-random sweep that moves both indices around the ring. A register request aimed at a cycle with a call is checked to stay unacknowledged.

// File: rtl/ret_addr_ring.sv
module ret_addr_ring #(
  parameter int DEPTH     = 16,
  parameter int PC_W      = 32,
  parameter int ST_W      = 8,
  parameter int OVF_LIMIT = DEPTH - 2,
  parameter int EXTRA_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       call_i,
  input  logic [PC_W-1:0]            call_pc_i,
  input  logic [ST_W-1:0]            call_st_i,
  input  logic                       ret_i,
  output logic [PC_W-1:0]            ret_pc_o,
  input  logic                       reg_req_i,
  input  logic                       reg_we_i,
  input  logic [1:0]                 reg_sel_i,
  input  logic [PC_W-1:0]            reg_wdata_i,
  output logic [PC_W-1:0]            reg_rdata_o,
  output logic                       reg_ack_o,
  output logic                       ovf_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       err_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(EXTRA_CYC + 2);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [CW-1:0] LIM  = CW'(OVF_LIMIT);
  localparam logic [TW-1:0] TSTART = TW'(EXTRA_CYC + 1);

  logic [PC_W-1:0] pc_mem [DEPTH];
  logic [ST_W-1:0] st_mem [DEPTH];
  logic [IW-1:0]   eld, yng;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tmr;
  logic            ovf_q, err_q;
  logic [PC_W-1:0] rdata_q;

  function automatic logic [IW-1:0] inc(input logic [IW-1:0] x);
    return (x == LAST) ? '0 : x + 1'b1;
  endfunction
  function automatic logic [IW-1:0] dec(input logic [IW-1:0] x);
    return (x == '0) ? LAST : x - 1'b1;
  endfunction

  wire empty     = (cnt == '0);
  wire full      = (cnt >= LIM);
  wire call_only = call_i && !ret_i;
  wire ret_only  = ret_i && !call_i;
  wire both      = call_i && ret_i;
  wire acc       = reg_req_i && (tmr == '0) && !call_i && !ret_i;
  wire e_push    = acc && reg_we_i && (reg_sel_i == 2'd0);
  wire ovf_evt   = (call_only || e_push) && full;
  wire acc_ok    = acc && !(e_push && full);

  assign ret_pc_o    = pc_mem[yng];
  assign reg_rdata_o = rdata_q;
  assign reg_ack_o   = (tmr == TW'(1));
  assign ovf_o       = ovf_q;
  assign count_o     = cnt;
  assign err_o       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eld     <= '0;
      yng     <= LAST;
      cnt     <= '0;
      tmr     <= '0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ovf_q <= ovf_evt;
      if (tmr != '0) tmr <= tmr - 1'b1;

      if (both) begin
        if (empty) begin
          err_q <= 1'b1;
          yng <= inc(yng);
          pc_mem[inc(yng)] <= call_pc_i;
          st_mem[inc(yng)] <= call_st_i;
          cnt <= CW'(1);
        end else begin
          pc_mem[yng] <= call_pc_i;
          st_mem[yng] <= call_st_i;
        end
      end else if (call_only && !full) begin
        yng <= inc(yng);
        pc_mem[inc(yng)] <= call_pc_i;
        st_mem[inc(yng)] <= call_st_i;
        cnt <= cnt + 1'b1;
      end else if (ret_only) begin
        if (empty) err_q <= 1'b1;
        else begin
          yng <= dec(yng);
          cnt <= cnt - 1'b1;
        end
      end

      if (acc_ok) begin
        tmr <= TSTART;
        case (reg_sel_i)
          2'd0: begin
            if (reg_we_i) begin
              eld <= dec(eld);
              pc_mem[dec(eld)] <= reg_wdata_i;
              st_mem[dec(eld)] <= '0;
              cnt <= cnt + 1'b1;
            end else begin
              rdata_q <= pc_mem[eld];
              if (empty) err_q <= 1'b1;
              else begin
                eld <= inc(eld);
                cnt <= cnt - 1'b1;
              end
            end
          end
          2'd1: begin
            if (empty) err_q <= 1'b1;
            if (reg_we_i) st_mem[eld] <= reg_wdata_i[ST_W-1:0];
            else rdata_q <= PC_W'(st_mem[eld]);
          end
          2'd2: begin
            if (empty) err_q <= 1'b1;
            if (reg_we_i) pc_mem[yng] <= reg_wdata_i;
            else rdata_q <= pc_mem[yng];
          end
          default: begin
            if (empty) err_q <= 1'b1;
            if (reg_we_i) st_mem[yng] <= reg_wdata_i[ST_W-1:0];
            else rdata_q <= PC_W'(st_mem[yng]);
          end
        endcase
      end
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((call_only || e_push) && full) |=> (cnt == $past(cnt) && eld == $past(eld) && yng == $past(yng)));

  assert_pair_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !empty) |=> (cnt == $past(cnt) && yng == $past(yng)));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack_o |=> !reg_ack_o);

  assert_ignore_with_call_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_i && (call_i || ret_i) && tmr == '0) |=> (eld == $past(eld)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_only && empty) |=> (cnt == '0 && err_q));
endmodule

// File: tb/ret_addr_ring_tb.sv
module ret_addr_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [31:0] call_pc_i = '0, reg_wdata_i = '0;
  logic [7:0]  call_st_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] ret_pc_o, reg_rdata_o;
  logic        reg_ack_o, ovf_o, err_o;
  logic [4:0]  count_o;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] mpc[$];
  logic [7:0]  mst[$];
  bit          merr = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_ring dut_i (
    .clk(clk), .rst_n(rst_n),
    .call_i(call_i), .call_pc_i(call_pc_i), .call_st_i(call_st_i),
    .ret_i(ret_i), .ret_pc_o(ret_pc_o),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .reg_ack_o(reg_ack_o),
    .ovf_o(ovf_o), .count_o(count_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input bit c, input bit r, input bit q, input bit we,
                        input logic [1:0] s, input logic [31:0] wd,
                        input logic [31:0] cp, input logic [7:0] cs, input string tag);
    int n;
    bit full, exp_ovf, exp_acc, chk_rd, ack_early;
    logic [31:0] exp_rd;
    n = mpc.size();
    full = (n >= LIM);
    exp_ovf = 0; exp_acc = 0; chk_rd = 0; exp_rd = '0;
    if (c && r) begin
      if (n == 0) begin merr = 1; mpc.push_back(cp); mst.push_back(cs); end
      else begin mpc[n-1] = cp; mst[n-1] = cs; end
    end else if (c) begin
      if (full) exp_ovf = 1;
      else begin mpc.push_back(cp); mst.push_back(cs); end
    end else if (r) begin
      if (n == 0) merr = 1;
      else begin void'(mpc.pop_back()); void'(mst.pop_back()); end
    end else if (q) begin
      if (s == 2'd0 && we && full) exp_ovf = 1;
      else begin
        exp_acc = 1;
        case (s)
          2'd0: if (we) begin mpc.push_front(wd); mst.push_front(8'h00); end
                else if (n == 0) merr = 1;
                else begin exp_rd = mpc[0]; chk_rd = 1; void'(mpc.pop_front()); void'(mst.pop_front()); end
          2'd1: if (n == 0) merr = 1;
                else if (we) mst[0] = wd[7:0];
                else begin exp_rd = {24'h0, mst[0]}; chk_rd = 1; end
          2'd2: if (n == 0) merr = 1;
                else if (we) mpc[n-1] = wd;
                else begin exp_rd = mpc[n-1]; chk_rd = 1; end
          default: if (n == 0) merr = 1;
                else if (we) mst[n-1] = wd[7:0];
                else begin exp_rd = {24'h0, mst[n-1]}; chk_rd = 1; end
        endcase
      end
    end
    call_i = c; ret_i = r; reg_req_i = q; reg_we_i = we; reg_sel_i = s;
    reg_wdata_i = wd; call_pc_i = cp; call_st_i = cs;
    @(negedge clk);
    call_i = 0; ret_i = 0; reg_req_i = 0; reg_we_i = 0;
    chk(ovf_o == exp_ovf, {tag, " R5 ovf_o"}, 32'(ovf_o), 32'(exp_ovf));
    chk(count_o == 5'(mpc.size()), {tag, " count_o"}, 32'(count_o), 32'(mpc.size()));
    chk(err_o == merr, {tag, " R11 err_o"}, 32'(err_o), 32'(merr));
    if (mpc.size() > 0)
      chk(ret_pc_o == mpc[mpc.size()-1], {tag, " R3 ret_pc_o"}, ret_pc_o, mpc[mpc.size()-1]);
    if (exp_acc) begin
      ack_early = 0;
      repeat (3) begin @(negedge clk); if (reg_ack_o) ack_early = 1; end
      chk(!ack_early, {tag, " R9 early ack"}, 32'(ack_early), 0);
      @(negedge clk);
      chk(reg_ack_o == 1'b1, {tag, " R9 ack"}, 32'(reg_ack_o), 1);
      if (chk_rd) chk(reg_rdata_o == exp_rd, {tag, " R8 rdata"}, reg_rdata_o, exp_rd);
      @(negedge clk);
    end else if (q) begin
      ack_early = 0;
      repeat (6) begin @(negedge clk); if (reg_ack_o) ack_early = 1; end
      chk(!ack_early, {tag, " R10 ignored request acked"}, 32'(ack_early), 0);
      chk(count_o == 5'(mpc.size()), {tag, " R10 count after ignore"}, 32'(count_o), 32'(mpc.size()));
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mpc.delete(); mst.delete(); merr = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    chk(count_o == 0, "R1 count", 32'(count_o), 0);
    chk(err_o == 0 && ovf_o == 0 && reg_ack_o == 0, "R1 flags", {29'h0, err_o, ovf_o, reg_ack_o}, 0);

    run_op(0, 1, 0, 0, 0, 0, 0, 0, "R11 ret on empty");
    run_op(0, 0, 1, 0, 0, 0, 0, 0, "R11 eldest read on empty");
    do_reset();
    run_op(1, 1, 0, 0, 0, 0, 32'h0000_A000, 8'h11, "R4 pair on empty");
    do_reset();

    for (int i = 0; i < LIM; i++)
      run_op(1, 0, 0, 0, 0, 0, 32'h1000 + 32'(i) * 4, 8'(i), "R2 call fill");
    run_op(1, 0, 0, 0, 0, 0, 32'hDEAD, 8'h0, "R5 call over limit");
    run_op(0, 0, 1, 1, 0, 32'hBEEF, 0, 0, "R5 eldest write over limit");
    run_op(1, 1, 0, 0, 0, 0, 32'h7777_0000, 8'h5A, "R4 pair replace");
    for (int s = 1; s < 4; s++) begin
      run_op(0, 0, 1, 1, 2'(s), 32'h0000_3300 + 32'(s), 0, 0, "R8 write");
      run_op(0, 0, 1, 0, 2'(s), 0, 0, 0, "R8 read");
    end
    for (int i = 0; i < 6; i++)
      run_op(0, 0, 1, 0, 0, 0, 0, 0, "R7 eldest spill");
    for (int i = 0; i < 4; i++)
      run_op(0, 0, 1, 1, 0, 32'h5000 + 32'(i), 0, 0, "R6 eldest refill");
    run_op(0, 1, 0, 0, 0, 0, 0, 0, "R3 return");
    run_op(1, 0, 1, 0, 0, 0, 32'h4242, 8'h3, "R10 request with call");
    run_op(0, 1, 1, 1, 2, 32'h99, 0, 0, "R10 request with return");

    reg_req_i = 1; reg_we_i = 0; reg_sel_i = 0;
    @(negedge clk);
    reg_req_i = 0;
    void'(mpc.pop_front()); void'(mst.pop_front());
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 0; reg_sel_i = 0;
    @(negedge clk);
    reg_req_i = 0;
    repeat (2) @(negedge clk);
    chk(reg_ack_o == 1'b1, "R9 ack of first request", 32'(reg_ack_o), 1);
    reg_req_i = 1;
    @(negedge clk);
    reg_req_i = 0;
    repeat (6) @(negedge clk);
    chk(count_o == 5'(mpc.size()), "R9 requests while busy ignored", 32'(count_o), 32'(mpc.size()));

    for (int k = 0; k < 1500; k++) begin
      logic [2:0] op;
      seed = seed * 32'd1103515245 + 32'd12345;
      op = seed[20:18];
      case (op)
        3'd0, 3'd1: run_op(1, 0, 0, 0, 0, 0, seed ^ 32'h0F0F, seed[7:0], "R2 sweep call");
        3'd2: run_op(0, 1, 0, 0, 0, 0, 0, 0, "R3 sweep ret");
        3'd3: run_op(1, 1, 0, 0, 0, 0, seed + 32'd7, seed[15:8], "R4 sweep pair");
        3'd4: run_op(0, 0, 1, 1, 0, seed ^ 32'hA5A5_0000, 0, 0, "R6 sweep refill");
        3'd5: run_op(0, 0, 1, 0, 0, 0, 0, 0, "R7 sweep spill");
        3'd6: run_op(0, 0, 1, seed[9], 2'd1 + 2'(seed[11:10] % 3), seed, 0, 0, "R8 sweep access");
        default: run_op(1, 0, 1, 0, 2'(seed[5:4]), 0, seed, 8'h0, "R10 sweep ignore");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule